// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a small set of hardware tokens that two independent ports, called left and right, use to claim a shared resource. A port selects a token with the low bits of its address and writes a 0 to ask for it. It writes a 1 to give the token back or to withdraw a request. It then reads the same token to learn whether it won. A read returns 0 on every data bit to the side that holds the token and 1 to every other side.

Each token remembers a request from each side. When one side holds a token and the other side is waiting, a release by the holder hands the token straight to the waiting side. No new request is needed. Both ports share one clock. Read data is captured in a register per port, so the value a port sees cannot change while the other port is writing.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free with no request pending. Both read data registers hold all ones, and a read of any token from either side returns all ones.
- R2: A semaphore access takes place when the port's select is high and its memory enable is low. The token index is the low 3 address bits (8 tokens), and the upper address bits have no effect.
- R3: A write with data bit 0 equal to 0 on a free token gives it to the writer. From the next cycle a read returns 8'h00 to the owner and 8'hFF to the other side, so the value appears on all data bits.
- R4: A write uses only data bit 0, and the other data bits have no effect. Bit 0 = 0 means request and bit 0 = 1 means release or cancel.
- R5: A request from one side while the other side holds the token leaves ownership unchanged.
- R6: When the holder writes 1 while the other side has a pending request, the waiting side owns the token from the next cycle. This works the same in both directions.
- R7: A side that writes 1 while it is waiting cancels its request. A later release by the holder then leaves the token free.
- R8: When both sides request a free token in the same cycle, exactly one side gets it, and that side is the left.
- R9: A write of 1 from a side that neither holds nor requests the token has no effect.
- R10: Read data is registered. It is updated one cycle after a read access, using the token state from before that cycle's writes, and it holds its value until the next read access of that port.
- R11: An access with both the select and the memory enable high is illegal and is ignored. It changes no token and no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; must be low for a semaphore access |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_addr | input | AW (14) | Left address; low 3 bits pick the token |
| l_wdata | input | DW (8) | Left write data; bit 0 used |
| l_rdata | output | DW (8) | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; must be low for a semaphore access |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_addr | input | AW (14) | Right address; low 3 bits pick the token |
| r_wdata | input | DW (8) | Right write data; bit 0 used |
| r_rdata | output | DW (8) | Right registered read data |

## Verification
A wrong owner flag shows up at the next read of that token: the read data flips between 8'h00 and 8'hFF one cycle after the read strobe. A lost or stale request flag stays hidden until the holder releases. It then shows as a token that stays free or one that moves to the wrong side, so the tests always follow a release with a read from both ports. A read register that tracks state instead of capturing it shows up only when a handover lands in the same cycle as a read. The tests build exactly that case and then wait idle cycles before reading again.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 14,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_mem_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_mem_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int IW = $clog2(NSEM);

  logic [NSEM-1:0] req_l, req_r, own_l, own_r;
  logic [IW-1:0]   l_ix, r_ix;
  logic            l_go, r_go, l_wr, r_wr, l_rd, r_rd;
  logic            unused_bits;

  assign l_go = l_sel & ~l_mem_en;
  assign r_go = r_sel & ~r_mem_en;
  assign l_wr = l_go & l_we;
  assign r_wr = r_go & r_we;
  assign l_rd = l_go & ~l_we;
  assign r_rd = r_go & ~r_we;
  assign l_ix = l_addr[IW-1:0];
  assign r_ix = r_addr[IW-1:0];
  assign unused_bits = ^{l_addr[AW-1:IW], r_addr[AW-1:IW], l_wdata[DW-1:1], r_wdata[DW-1:1]};

  for (genvar i = 0; i < NSEM; i++) begin : g_tok
    logic hit_l, hit_r, nl, nr, keep_r, nxt_l;
    assign hit_l  = l_wr && (l_ix == IW'(i));
    assign hit_r  = r_wr && (r_ix == IW'(i));
    assign nl     = hit_l ? ~l_wdata[0] : req_l[i];
    assign nr     = hit_r ? ~r_wdata[0] : req_r[i];
    assign keep_r = own_r[i] & nr;
    assign nxt_l  = (own_l[i] & nl) | (~keep_r & nl);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_l[i] <= 1'b0;
        req_r[i] <= 1'b0;
        own_l[i] <= 1'b0;
        own_r[i] <= 1'b0;
      end else begin
        req_l[i] <= nl;
        req_r[i] <= nr;
        own_l[i] <= nxt_l;
        own_r[i] <= nr & ~nxt_l;
      end
    end

    AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[i] && !(hit_l && l_wdata[0]) |=> own_l[i]); // R5
    AST_HANDOVER_R: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[i] && req_r[i] && hit_l && l_wdata[0] && !(hit_r && r_wdata[0]) |=> own_r[i]); // R6
    AST_HANDOVER_L: assert property (@(posedge clk) disable iff (!rst_n)
      own_r[i] && req_l[i] && hit_r && r_wdata[0] && !(hit_l && l_wdata[0]) |=> own_l[i]); // R6
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[i] && !own_r[i] && hit_l && !l_wdata[0] && hit_r && !r_wdata[0]
      |=> own_l[i] && !own_r[i]); // R8
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[i] && !req_l[i] && hit_l && l_wdata[0] && !hit_r
      |=> own_r[i] == $past(own_r[i]) && !own_l[i]); // R9
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_rd) l_rdata <= {DW{~own_l[l_ix]}};
      if (r_rd) r_rdata <= {DW{~own_r[r_ix]}};
    end
  end

  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    l_sel && l_mem_en && !r_sel |=> $stable(own_l) && $stable(req_l) && $stable(l_rdata)); // R11
  AST_RD_SEES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |=> l_rdata == {DW{~$past(own_l[l_ix])}}); // R10
endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  localparam int AW = 14;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_mem_en = 0, l_we = 0;
  logic r_sel = 0, r_mem_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sem_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_we(l_we), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_we(r_we), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // {left act, left idx, right act, right idx, check idx, exp left, exp right, req}
  // act: 0 idle, 1 write 0 (request), 2 write 1 (release)
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 3'd3, 2'd0, 3'd0, 3'd3, 1'b0, 1'b1, 4'd3},  // R3 left takes free token
    {2'd0, 3'd0, 2'd1, 3'd3, 3'd3, 1'b0, 1'b1, 4'd5},  // R5 right waits
    {2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0, 4'd6},  // R6 handover to right
    {2'd1, 3'd3, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0, 4'd5},  // R5 left waits
    {2'd0, 3'd0, 2'd2, 3'd3, 3'd3, 1'b0, 1'b1, 4'd6},  // R6 handover to left
    {2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b1, 1'b1, 4'd3},  // R3 release frees
    {2'd1, 3'd5, 2'd1, 3'd5, 3'd5, 1'b0, 1'b1, 4'd8},  // R8 tie goes left
    {2'd0, 3'd0, 2'd2, 3'd5, 3'd5, 1'b0, 1'b1, 4'd7},  // R7 right cancels
    {2'd2, 3'd5, 2'd0, 3'd0, 3'd5, 1'b1, 1'b1, 4'd7},  // R7 no handover after cancel
    {2'd0, 3'd0, 2'd2, 3'd6, 3'd6, 1'b1, 1'b1, 4'd9},  // R9 idle release on free token
    {2'd0, 3'd0, 2'd1, 3'd0, 3'd0, 1'b1, 1'b0, 4'd3},  // R3 right takes token 0
    {2'd2, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd9},  // R9 left idle release
    {2'd1, 3'd7, 2'd0, 3'd0, 3'd6, 1'b1, 1'b1, 4'd2},  // R2 neighbour untouched
    {2'd0, 3'd0, 2'd2, 3'd0, 3'd7, 1'b0, 1'b1, 4'd2}   // R2 token 7 still left
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_l(input logic [1:0] a, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    l_sel = (a != 0); l_we = 1'b1; l_addr = ad;
    l_wdata = (a == 2'd1) ? wd : 8'hFF;
  endtask

  task automatic drive_r(input logic [1:0] a, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    r_sel = (a != 0); r_we = 1'b1; r_addr = ad;
    r_wdata = (a == 2'd1) ? wd : 8'hFF;
  endtask

  task automatic idle;
    l_sel = 0; l_we = 0; l_mem_en = 0; r_sel = 0; r_we = 0; r_mem_en = 0;
  endtask

  task automatic step(input logic [1:0] la, input logic [AW-1:0] lad, input logic [1:0] ra, input logic [AW-1:0] rad);
    @(negedge clk);
    drive_l(la, lad, 8'h00);
    drive_r(ra, rad, 8'h00);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_both(input logic [AW-1:0] la, input logic [AW-1:0] ra,
                         input logic el, input logic er, input string req);
    @(negedge clk);
    l_sel = 1; l_we = 0; l_addr = la;
    r_sel = 1; r_we = 0; r_addr = ra;
    @(negedge clk);
    idle();
    check({req, " left"}, l_rdata, {DW{el}});
    check({req, " right"}, r_rdata, {DW{er}});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdata left", l_rdata, 8'hFF);
    check("R1 reset rdata right", r_rdata, 8'hFF);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) rd_both(AW'(k), AW'(k), 1'b1, 1'b1, "R1 free");

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      step(e[18:17], AW'(e[16:14]), e[13:12], AW'(e[11:9]));
      rd_both(AW'(e[8:6]), AW'(e[8:6]), e[5], e[4], $sformatf("R%0d vec %0d", e[3:0], v));
    end
    step(2'd2, AW'(7), 2'd0, '0);

    // R2: upper address bits ignored
    step(2'd1, 14'h2A0D, 2'd0, '0);
    rd_both(14'h1FFD, 14'h0005, 1'b0, 1'b1, "R2 upper bits");
    step(2'd2, 14'h3FF5, 2'd0, '0);
    rd_both(14'h0005, 14'h3C05, 1'b1, 1'b1, "R2 release via alias");

    // R4: only bit 0 of write data matters
    @(negedge clk); drive_l(2'd1, AW'(6), 8'hFE); @(negedge clk); idle();
    rd_both(AW'(6), AW'(6), 1'b0, 1'b1, "R4 data FE requests");
    @(negedge clk); l_sel = 1; l_we = 1; l_addr = AW'(6); l_wdata = 8'h01; @(negedge clk); idle();
    rd_both(AW'(6), AW'(6), 1'b1, 1'b1, "R4 data 01 releases");

    // R10: left read in the same cycle as a handover captures the old state
    step(2'd0, '0, 2'd1, AW'(4));
    step(2'd1, AW'(4), 2'd0, '0);
    @(negedge clk);
    l_sel = 1; l_we = 0; l_addr = AW'(4);
    r_sel = 1; r_we = 1; r_addr = AW'(4); r_wdata = 8'hFF;
    @(negedge clk); idle();
    check("R10 read before handover", l_rdata, 8'hFF);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", l_rdata, 8'hFF);
    rd_both(AW'(4), AW'(4), 1'b0, 1'b1, "R10 later read");

    // R11: select with memory enable is ignored
    @(negedge clk);
    l_sel = 1; l_mem_en = 1; l_we = 1; l_addr = AW'(1); l_wdata = 8'h00;
    @(negedge clk); idle();
    rd_both(AW'(1), AW'(1), 1'b1, 1'b1, "R11 illegal write");
    @(negedge clk);
    l_sel = 1; l_mem_en = 1; l_we = 0; l_addr = AW'(4);
    @(negedge clk); idle();
    check("R11 illegal read keeps rdata", l_rdata, 8'hFF);

    // R1: reset in mid run frees every token
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 rdata after reset", l_rdata, 8'hFF);
    rd_both(AW'(4), AW'(4), 1'b1, 1'b1, "R1 token 4 free");
    step(2'd0, '0, 2'd1, AW'(4));
    rd_both(AW'(4), AW'(4), 1'b1, 1'b0, "R1 no stale request");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule